// File: doc/BRIEF.md
# Nested Loop Program Sequencer

The sequencer walks through a program held in an external synchronous memory. It decides on one program row per clock. Every row is a 32-bit word with three parts: an 8-bit payload that is driven onto the output, a 4-bit auxiliary count, and a 20-bit control field. The control field marks the row as one of four kinds: a plain row, a row that opens a hardware loop and gives its iteration count, a row that closes one or more loops, or the end of the program.

Loops may be nested up to eight deep. The sequencer keeps the return address and the remaining iterations of each open loop on an internal stack. A single closing row can close several nested loops at once. It unwinds them innermost first and jumps back to the first of them that still has iterations left.

A start strobe restarts execution at address 0. The first cycle after the strobe is a fetch bubble, because the memory answers one cycle after it is addressed. After that, jumps cost no cycles. Execution stops at the end-of-program row, which raises done. It also stops on a malformed loop structure, which raises err. In both cases the sequencer waits for the next strobe.

Top module: `loopseq`

## Requirements
- R1: While reset is held and after it is released, out_valid, done and err are 0 and out_data is 0 until a start strobe is applied.
- R2: A row word is laid out as payload in bits [31:24], auxiliary count in bits [23:20] and control field in bits [19:0]. A control field of 0x00000 is a plain row. Its payload appears on out_data with out_valid high on the clock edge after the row word is on mem_rdata, and execution moves to the next address.
- R3: start restarts at address 0 and clears the loop stack, done and err. During the cycle after the edge that samples start, mem_addr is 0 and out_valid is 0. The payload of row 0 appears on the second edge after the edge that samples start.
- R4: A control field other than 0x00000, 0xFFFFE and 0xFFFFF opens a loop whose body runs that many times, from 1 up to about one million. The opening row emits its payload once.
- R5: A control field of 0xFFFFE closes a loop and emits its payload. If the innermost loop has iterations left, execution continues at the row after that loop's opening row. Otherwise the loop is dropped and execution moves on by one.
- R6: On a closing row with auxiliary count n, n+1 loops are closed innermost first. Execution jumps to the body start of the first of them that still has iterations left, and the loops inside it are dropped. If none has iterations left, all n+1 are dropped and execution moves on by one.
- R7: Eight levels of nesting work, including a single closing row that closes all eight.
- R8: An opening row met while eight loops are open emits nothing, leaves the stack untouched, sets err and stops with out_valid low and done low.
- R9: A closing row whose auxiliary count is not below the number of open loops emits nothing, sets err and stops.
- R10: A control field of 0xFFFFF emits nothing. It sets done, drops out_valid, keeps out_data at its last value and stops until the next start.
- R11: Rows, including rows reached by a jump, produce output on consecutive clocks with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load/start strobe, restarts at address 0 |
| mem_addr | output | 13 | Program memory read address |
| mem_rdata | input | 32 | Row word, one cycle after its address |
| out_data | output | 8 | Payload of the last executed row |
| out_valid | output | 1 | out_data holds a row executed in the previous cycle |
| done | output | 1 | Program reached its end row |
| err | output | 1 | Loop nesting fault, execution stopped |

## Verification
A wrong loop counter or return address on the stack shows up at the ports as a wrong payload sequence. It appears on the cycle the affected closing row is decided, which is one clock after that row reaches mem_rdata. A wrong stack depth stays hidden until a later closing or opening row. At that point err rises when it should not, or is missing when it should rise, or the run ends early or late. The bench compares every output on every clock against a behavioural model. It also compares the total count of emitted rows per program with a number worked out by hand, so that a drift in the loop count is caught even when the model and the design agree on the sequence order.

// File: rtl/loopseq_pkg.sv
package loopseq_pkg;

    parameter int DATA_W   = 8;
    parameter int AUX_W    = 4;
    parameter int FLAG_W   = 20;
    parameter int ADDR_W   = 13;
    parameter int MAX_NEST = 8;

    localparam int ROW_W = DATA_W + AUX_W + FLAG_W;

    localparam logic [FLAG_W-1:0] FLAG_PLAIN = '0;
    localparam logic [FLAG_W-1:0] FLAG_CLOSE = {{(FLAG_W-1){1'b1}}, 1'b0};
    localparam logic [FLAG_W-1:0] FLAG_HALT  = '1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [AUX_W-1:0]  aux;
        logic [FLAG_W-1:0] flag;
    } row_t;

    typedef enum logic [1:0] {K_PLAIN, K_OPEN, K_CLOSE, K_HALT} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_STOP} state_e;
    typedef enum logic [1:0] {OP_NONE, OP_PUSH, OP_CLOSE} stk_op_e;

    function automatic kind_e classify(input logic [FLAG_W-1:0] f);
        if (f == FLAG_PLAIN)      return K_PLAIN;
        else if (f == FLAG_CLOSE) return K_CLOSE;
        else if (f == FLAG_HALT)  return K_HALT;
        else                      return K_OPEN;
    endfunction

endpackage

// File: rtl/loopseq_decode.sv
module loopseq_decode
    import loopseq_pkg::*;
(
    input  logic [ROW_W-1:0] word,
    output row_t             row,
    output kind_e            kind
);
    always_comb begin
        row  = row_t'(word);
        kind = classify(row.flag);
    end
endmodule

// File: rtl/loopseq_stack.sv
module loopseq_stack
    import loopseq_pkg::*;
#(
    parameter int DEPTH = MAX_NEST,
    parameter int AW    = ADDR_W,
    parameter int CW    = FLAG_W,
    parameter int NW    = AUX_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  stk_op_e                      op,
    input  logic [AW-1:0]                push_ret,
    input  logic [CW-1:0]                push_cnt,
    input  logic [NW-1:0]                close_n,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         short,
    output logic                         back,
    output logic [AW-1:0]                back_addr
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]    ret_q [DEPTH];
    logic [CW-1:0]    cnt_q [DEPTH];
    logic [LVL_W-1:0] level_q;

    logic             hit_found;
    logic [LVL_W-1:0] hit_k;
    logic [IDX_W-1:0] hit_slot;
    logic [IDX_W-1:0] top_slot;

    // slot holding the entry k places below the top of the stack
    function automatic logic [IDX_W-1:0] slot_of(input logic [LVL_W-1:0] lv, input int k);
        int t;
        t = int'(lv) - 1 - k;
        return IDX_W'(t);
    endfunction

    always_comb begin
        hit_found = 1'b0;
        hit_k     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!hit_found && k <= int'(close_n) && k < int'(level_q)) begin
                if (cnt_q[slot_of(level_q, k)] != '0) begin
                    hit_found = 1'b1;
                    hit_k     = LVL_W'(k);
                end
            end
        end
    end

    assign hit_slot  = slot_of(level_q, int'(hit_k));
    assign top_slot  = IDX_W'(level_q);
    assign full      = (level_q == LVL_W'(DEPTH));
    assign short     = (int'(close_n) >= int'(level_q));
    assign back      = hit_found && !short;
    assign back_addr = ret_q[hit_slot];
    assign level     = level_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            level_q <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    if (!full) begin
                        ret_q[top_slot] <= push_ret;
                        cnt_q[top_slot] <= push_cnt;
                        level_q         <= level_q + LVL_W'(1);
                    end
                end
                OP_CLOSE: begin
                    if (!short) begin
                        if (hit_found) begin
                            cnt_q[hit_slot] <= cnt_q[hit_slot] - CW'(1);
                            level_q         <= level_q - hit_k;
                        end else begin
                            level_q <= level_q - LVL_W'(close_n) - LVL_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/loopseq.sv
module loopseq
    import loopseq_pkg::*;
#(
    parameter int DEPTH = MAX_NEST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [ROW_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              done,
    output logic              err
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    state_e            state_q;
    logic [ADDR_W-1:0] cur_q;
    row_t              row;
    kind_e             kind;
    stk_op_e           op;
    logic              fault;
    logic              halting;
    logic [ADDR_W-1:0] nxt;
    logic [LVL_W-1:0]  nest_level;
    logic              stk_full, stk_short, stk_back;
    logic [ADDR_W-1:0] stk_back_addr;

    loopseq_decode u_dec (
        .word (mem_rdata),
        .row  (row),
        .kind (kind)
    );

    loopseq_stack #(
        .DEPTH (DEPTH),
        .AW    (ADDR_W),
        .CW    (FLAG_W),
        .NW    (AUX_W)
    ) u_stk (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .op        (op),
        .push_ret  (cur_q + ADDR_W'(1)),
        .push_cnt  (row.flag - FLAG_W'(1)),
        .close_n   (row.aux),
        .level     (nest_level),
        .full      (stk_full),
        .short     (stk_short),
        .back      (stk_back),
        .back_addr (stk_back_addr)
    );

    // next-row decision, made from the row now on the read port
    always_comb begin
        op    = OP_NONE;
        fault = 1'b0;
        nxt   = cur_q + ADDR_W'(1);
        if (state_q == S_RUN) begin
            case (kind)
                K_OPEN: begin
                    fault = stk_full;
                    op    = OP_PUSH;
                end
                K_CLOSE: begin
                    fault = stk_short;
                    op    = OP_CLOSE;
                    if (stk_back) nxt = stk_back_addr;
                end
                K_HALT:  nxt = cur_q;
                default: ;
            endcase
            if (fault) nxt = cur_q;
        end
        if (start) op = OP_NONE;
    end

    assign halting = (state_q == S_RUN) && ((kind == K_HALT) || fault);

    always_comb begin
        case (state_q)
            S_FETCH: mem_addr = '0;
            S_RUN:   mem_addr = nxt;
            default: mem_addr = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            cur_q     <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else if (start) begin
            state_q   <= S_FETCH;
            out_valid <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            case (state_q)
                S_FETCH: begin
                    state_q   <= S_RUN;
                    cur_q     <= '0;
                    out_valid <= 1'b0;
                end
                S_RUN: begin
                    if (halting) begin
                        state_q   <= S_STOP;
                        out_valid <= 1'b0;
                        done      <= (kind == K_HALT) && !fault;
                        err       <= fault;
                    end else begin
                        cur_q     <= nxt;
                        out_data  <= row.data;
                        out_valid <= 1'b1;
                    end
                end
                default: out_valid <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/loopseq_check.sv
module loopseq_check
    import loopseq_pkg::*;
#(
    parameter int DEPTH = MAX_NEST,
    parameter int LVL_W = $clog2(MAX_NEST + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              done,
    input logic              err,
    input logic [LVL_W-1:0]  nest_level
);
    p_bubble_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> (!out_valid && mem_addr == '0));

    p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && !out_valid && $stable(out_data)));

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> (err && !out_valid && $stable(mem_addr)));

    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> (!done && !out_valid));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        int'(nest_level) <= DEPTH);
endmodule

bind loopseq loopseq_check #(
    .DEPTH (DEPTH),
    .LVL_W ($clog2(DEPTH + 1))
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mem_addr   (mem_addr),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .done       (done),
    .err        (err),
    .nest_level (nest_level)
);

// File: tb/sim_loopseq.sv
module sim_loopseq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [12:0] mem_addr;
    logic [31:0] rdata = '0;
    logic [7:0]  out_data;
    logic        out_valid, done, err;

    logic [31:0] mem [256];

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    loopseq u0 (
        .clk(clk), .rst(rst), .start(start), .mem_addr(mem_addr),
        .mem_rdata(rdata), .out_data(out_data), .out_valid(out_valid),
        .done(done), .err(err)
    );

    always @(posedge clk) rdata <= mem[mem_addr[7:0]];

    // behavioural reference: 0 idle, 1 fetch, 2 run, 3 stopped
    int m_mode = 0, m_pc = 0;
    int sret[$];
    int scnt[$];
    bit m_valid = 0, m_done = 0, m_err = 0;
    logic [7:0] m_data = '0;

    always @(posedge clk) begin
        logic [31:0] w;
        int a, f, k;
        bit jumped;
        if (rst) begin
            m_mode = 0; m_pc = 0; sret.delete(); scnt.delete();
            m_valid = 0; m_data = '0; m_done = 0; m_err = 0;
        end else if (start) begin
            m_mode = 1; sret.delete(); scnt.delete();
            m_valid = 0; m_done = 0; m_err = 0;
        end else if (m_mode == 1) begin
            m_mode = 2; m_pc = 0; m_valid = 0;
        end else if (m_mode == 2) begin
            w = mem[m_pc % 256];
            a = int'(w[23:20]);
            f = int'(w[19:0]);
            if (f == 0) begin
                m_data = w[31:24]; m_valid = 1; m_pc = m_pc + 1;
            end else if (f == 'hFFFFF) begin
                m_valid = 0; m_done = 1; m_mode = 3;
            end else if (f == 'hFFFFE) begin
                if (a + 1 > sret.size()) begin
                    m_valid = 0; m_err = 1; m_mode = 3;
                end else begin
                    jumped = 0; k = 0;
                    while (!jumped && k <= a) begin
                        if (scnt[scnt.size()-1] > 0) begin
                            scnt[scnt.size()-1] = scnt[scnt.size()-1] - 1;
                            m_pc = sret[sret.size()-1];
                            jumped = 1;
                        end else begin
                            void'(sret.pop_back());
                            void'(scnt.pop_back());
                        end
                        k++;
                    end
                    if (!jumped) m_pc = m_pc + 1;
                    m_data = w[31:24]; m_valid = 1;
                end
            end else begin
                if (sret.size() == 8) begin
                    m_valid = 0; m_err = 1; m_mode = 3;
                end else begin
                    sret.push_back((m_pc + 1) % 8192);
                    scnt.push_back(f - 1);
                    m_data = w[31:24]; m_valid = 1; m_pc = m_pc + 1;
                end
            end
            m_pc = m_pc % 8192;
        end else begin
            m_valid = 0;
        end
    end

    task automatic check(input string t, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h", t, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            check(tag, "out_valid", int'(out_valid), int'(m_valid));
            check(tag, "done", int'(done), int'(m_done));
            check(tag, "err", int'(err), int'(m_err));
            check(tag, "out_data", int'(out_data), int'(m_data));
        end
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL R11 watchdog: cycles %0d expected below %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input int d, input int aux, input int flag);
        return {d[7:0], aux[3:0], flag[19:0]};
    endfunction

    localparam int PLAIN = 0;
    localparam int CLOSE = 'hFFFFE;
    localparam int HALT  = 'hFFFFF;

    task automatic wipe();
        for (int i = 0; i < 256; i++) mem[i] = mk('hEE, 0, HALT);
    endtask

    task automatic run_prog(input string t, input int exp_cnt, input int exp_last,
                            input bit exp_done, input bit exp_err);
        int cnt;
        int lim;
        tag = t;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R3", "bubble out_valid", int'(out_valid), 0);
        check("R3", "bubble mem_addr", int'(mem_addr), 0);
        cnt = 0; lim = 0;
        while (!done && !err && lim < 20000) begin
            @(negedge clk);
            if (out_valid) cnt++;
            lim++;
        end
        repeat (3) @(negedge clk);
        check(t, "emitted rows", cnt, exp_cnt);
        check(t, "last payload", int'(out_data), exp_last);
        check(t, "done flag", int'(done), int'(exp_done));
        check(t, "err flag", int'(err), int'(exp_err));
    endtask

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);
        check("R1", "reset out_valid", int'(out_valid), 0);
        check("R1", "reset done", int'(done), 0);
        check("R1", "reset err", int'(err), 0);
        check("R1", "reset out_data", int'(out_data), 0);

        // R2 R10: plain rows then end of program
        wipe();
        mem[0] = mk('h11, 0, PLAIN); mem[1] = mk('h22, 0, PLAIN);
        mem[2] = mk('h33, 0, PLAIN); mem[3] = mk('h44, 0, PLAIN);
        run_prog("R2_R10", 4, 'h44, 1, 0);
        repeat (5) @(negedge clk);
        check("R10", "held payload", int'(out_data), 'h44);
        check("R10", "still done", int'(done), 1);

        // R4 R5 R11: single loop of three, back-to-back output through jumps
        wipe();
        mem[0] = mk('hA0, 0, 3); mem[1] = mk('hB1, 0, PLAIN);
        mem[2] = mk('hC2, 0, CLOSE);
        run_prog("R4_R5_R11", 7, 'hC2, 1, 0);

        // R5: two nested loops with their own closing rows
        wipe();
        mem[0] = mk('h10, 0, 2); mem[1] = mk('h20, 0, 3);
        mem[2] = mk('h30, 0, PLAIN); mem[3] = mk('h40, 0, CLOSE);
        mem[4] = mk('h50, 0, CLOSE);
        run_prog("R5_nested", 17, 'h50, 1, 0);

        // R6: one closing row closes two loops, outer jump target
        wipe();
        mem[0] = mk('h01, 0, 2); mem[1] = mk('h02, 0, PLAIN);
        mem[2] = mk('h03, 0, 3); mem[3] = mk('h04, 0, PLAIN);
        mem[4] = mk('h05, 1, CLOSE);
        run_prog("R6_multi", 17, 'h05, 1, 0);

        // R7: eight levels closed by one row
        wipe();
        for (int i = 0; i < 8; i++) mem[i] = mk('h60 + i, 0, 2);
        mem[8] = mk('h70, 0, PLAIN); mem[9] = mk('h71, 7, CLOSE);
        run_prog("R7_deep", 767, 'h71, 1, 0);

        // R8: ninth level opened
        wipe();
        for (int i = 0; i < 9; i++) mem[i] = mk('h80 + i, 0, 2);
        mem[9] = mk('h99, 0, PLAIN);
        run_prog("R8_overflow", 8, 'h87, 0, 1);

        // R9: closing with nothing open, and closing too many
        wipe();
        mem[0] = mk('h90, 0, PLAIN); mem[1] = mk('h9F, 0, CLOSE);
        run_prog("R9_empty", 1, 'h90, 0, 1);
        wipe();
        mem[0] = mk('h91, 0, 2); mem[1] = mk('h9E, 2, CLOSE);
        run_prog("R9_short", 1, 'h91, 0, 1);

        // R4: count of one, and a count wider than eight bits
        wipe();
        mem[0] = mk('hA1, 0, 1); mem[1] = mk('hA2, 0, PLAIN);
        mem[2] = mk('hA3, 0, CLOSE);
        run_prog("R4_once", 3, 'hA3, 1, 0);
        wipe();
        mem[0] = mk('hB0, 0, 261); mem[1] = mk('hB1, 0, PLAIN);
        mem[2] = mk('hB2, 0, CLOSE);
        run_prog("R4_wide", 523, 'hB2, 1, 0);

        // R3: restart in the middle of a run
        wipe();
        mem[0] = mk('hA0, 0, 3); mem[1] = mk('hB1, 0, PLAIN);
        mem[2] = mk('hC2, 0, CLOSE);
        tag = "R3_restart";
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        run_prog("R3_restart", 7, 'hC2, 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule